// File: doc/BRIEF.md
# Bipolar Return-to-Zero Line Encoder with Alarm Fill and Loopback

This block turns a transmit bit stream into a bipolar return-to-zero line signal carried on two logic-level rails, one for positive pulses and one for negative pulses. It runs from a system clock that is a fixed even multiple of the bit rate. An internal divider marks the bit periods. Each rail may pulse only during the first half of a bit period.

Data enters in one of two ways. In single-rail entry, a one becomes a mark, and successive marks alternate between the two rails. In dual-rail entry, the caller supplies the marks already placed on their rails.

Two overrides sit above normal data. An alarm-fill request sends a mark in every bit. A remote loopback sends the received rail pair back out to the line. Loopback outranks the alarm request. Every source decision is taken once per bit, at the bit boundary.

Top module: `ami_line_tx`

## Requirements
- R1: With `all_ones_req` high and `loopback_en` low at a bit boundary, the following bit carries a mark whose polarity is the opposite of the previous AMI-generated mark.
- R2: While the alarm fill is in effect, `tx_pos`, `tx_neg`, `tx_data` and `dual_rail_mode` have no effect on the rails.
- R3: With `loopback_en` high at a bit boundary, the following bit carries `rx_pos` on `line_pos` and `rx_neg` on `line_neg`. `all_ones_req` is ignored, and the AMI polarity is left unchanged.
- R4: In single-rail entry (`dual_rail_mode` = 0), a `tx_data` one produces a mark on the rail selected by the polarity state, and a zero produces no pulse on either rail.
- R5: The polarity state changes only on AMI-generated marks, from single-rail data or from alarm fill. After reset, the first such mark is positive.
- R6: In dual-rail entry (`dual_rail_mode` = 1), `tx_pos` and `tx_neg` pass to `line_pos` and `line_neg` unchanged and do not affect the polarity state.
- R7: A rail pair with both inputs high, whether dual-rail transmit data or loopback receive data, is sent as a zero. `line_pos` and `line_neg` are never high together.
- R8: A bit period lasts `CLK_PER_BIT` clocks. `bit_start` is high in its first clock. A mark holds its rail high for the first `CLK_PER_BIT/2` clocks and low for the rest. Inputs held during one bit appear on the rails in the next bit.
- R9: Inputs are sampled only at the bit boundary. Input changes in the middle of a bit that are undone before the boundary have no effect on the rails.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, `CLK_PER_BIT` cycles per bit |
| rst_n | input | 1 | Active-low synchronous reset |
| dual_rail_mode | input | 1 | 1 selects dual-rail entry, 0 selects single-rail AMI entry |
| all_ones_req | input | 1 | Alarm fill request |
| loopback_en | input | 1 | Remote loopback enable |
| tx_pos | input | 1 | Dual-rail positive mark |
| tx_neg | input | 1 | Dual-rail negative mark |
| tx_data | input | 1 | Single-rail data bit |
| rx_pos | input | 1 | Received positive mark, used for loopback |
| rx_neg | input | 1 | Received negative mark, used for loopback |
| line_pos | output | 1 | Positive pulse rail enable |
| line_neg | output | 1 | Negative pulse rail enable |
| bit_start | output | 1 | High in the first clock of each bit period |

## Verification
A corrupted polarity state shows one bit after the next AMI mark, as a pulse on the wrong rail. The bench tracks polarity across every input combination, so such an error cannot stay hidden for more than one mark. A fault in the bit divider or the half-bit gate shows inside a single bit period, as pulses of the wrong length or a misplaced `bit_start`. A source-priority or mid-bit sampling fault shows in the bit after the boundary where it acted. The bench sweeps all 256 combinations of the eight data and control inputs. In the same runs it toggles the inputs in the middle of each bit and expects no effect.

// File: rtl/ami_tx_pkg.sv
package ami_tx_pkg;

   typedef enum logic [1:0] {
      SRC_SINGLE = 2'd0,
      SRC_DUAL   = 2'd1,
      SRC_ONES   = 2'd2,
      SRC_LOOP   = 2'd3
   } src_e;

   typedef struct packed {
      logic pos;
      logic neg;
   } rails_t;

   localparam rails_t RAILS_IDLE = '{pos: 1'b0, neg: 1'b0};

   function automatic rails_t clean_pair(input logic p, input logic n);
      rails_t r;
      r.pos = p & ~n;
      r.neg = n & ~p;
      return r;
   endfunction

endpackage

// File: rtl/ami_bit_timer.sv
module ami_bit_timer #(
   parameter int CLK_PER_BIT = 4,
   localparam int PW = (CLK_PER_BIT > 2) ? $clog2(CLK_PER_BIT) : 1,
   localparam int HALF = CLK_PER_BIT / 2
) (
   input  logic          clk,
   input  logic          rst_n,
   output logic [PW-1:0] phase,
   output logic          bit_end,
   output logic          bit_begin,
   output logic          first_half
);

   localparam logic [PW-1:0] LAST   = PW'(CLK_PER_BIT - 1);
   localparam logic [PW-1:0] HALF_P = PW'(HALF);

   generate
      if (CLK_PER_BIT < 2 || (CLK_PER_BIT % 2) != 0) begin : g_bad_div
         $error("CLK_PER_BIT must be even and at least 2");
      end
   endgenerate

   logic [PW-1:0] ph_q;

   always_ff @(posedge clk) begin
      if (!rst_n)          ph_q <= '0;
      else if (ph_q == LAST) ph_q <= '0;
      else                 ph_q <= ph_q + 1'b1;
   end

   assign phase      = ph_q;
   assign bit_end    = (ph_q == LAST);
   assign bit_begin  = (ph_q == '0);
   assign first_half = (ph_q < HALF_P);

   p_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      bit_end |=> bit_begin);
   p_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_end |=> (ph_q == $past(ph_q) + 1'b1));

endmodule

// File: rtl/ami_src_select.sv
module ami_src_select
   import ami_tx_pkg::*;
(
   input  logic   dual_rail_mode,
   input  logic   all_ones_req,
   input  logic   loopback_en,
   input  logic   tx_pos,
   input  logic   tx_neg,
   input  logic   tx_data,
   input  logic   rx_pos,
   input  logic   rx_neg,
   output src_e   src,
   output rails_t direct,
   output logic   ami_mark
);

   always_comb begin
      if (loopback_en)         src = SRC_LOOP;
      else if (all_ones_req)   src = SRC_ONES;
      else if (dual_rail_mode) src = SRC_DUAL;
      else                     src = SRC_SINGLE;
   end

   always_comb begin
      direct   = RAILS_IDLE;
      ami_mark = 1'b0;
      unique case (src)
         SRC_LOOP:   direct   = clean_pair(rx_pos, rx_neg);
         SRC_DUAL:   direct   = clean_pair(tx_pos, tx_neg);
         SRC_ONES:   ami_mark = 1'b1;
         SRC_SINGLE: ami_mark = tx_data;
         default:    ami_mark = 1'b0;
      endcase
   end

   always_comb begin
      if (ami_mark) begin
         a_no_direct_r7: assert (direct == RAILS_IDLE);
      end
   end

endmodule

// File: rtl/ami_polarity_enc.sv
module ami_polarity_enc
   import ami_tx_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   bit_end,
   input  rails_t direct,
   input  logic   ami_mark,
   output rails_t rails_q
);

   logic pol_q;   // 0: next AMI mark goes positive

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pol_q   <= 1'b0;
         rails_q <= RAILS_IDLE;
      end else if (bit_end) begin
         if (ami_mark) begin
            rails_q.pos <= ~pol_q;
            rails_q.neg <= pol_q;
            pol_q       <= ~pol_q;
         end else begin
            rails_q     <= direct;
         end
      end
   end

   p_ami_flip_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_end && ami_mark) |=> (pol_q != $past(pol_q)));
   p_pol_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_end && !ami_mark) |=> $stable(pol_q));
   p_midbit_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_end |=> ($stable(rails_q) && $stable(pol_q)));
   p_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(rails_q.pos && rails_q.neg));

endmodule

// File: rtl/ami_rz_gate.sv
module ami_rz_gate
   import ami_tx_pkg::*;
(
   input  rails_t     rails_q,
   input  logic       first_half,
   output logic [1:0] rz_out
);

   logic [1:0] held;
   assign held = {rails_q.pos, rails_q.neg};

   generate
      for (genvar i = 0; i < 2; i++) begin : g_rail
         assign rz_out[i] = held[i] & first_half;
      end
   endgenerate

endmodule

// File: rtl/ami_line_tx.sv
module ami_line_tx
   import ami_tx_pkg::*;
#(
   parameter int CLK_PER_BIT = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic dual_rail_mode,
   input  logic all_ones_req,
   input  logic loopback_en,
   input  logic tx_pos,
   input  logic tx_neg,
   input  logic tx_data,
   input  logic rx_pos,
   input  logic rx_neg,
   output logic line_pos,
   output logic line_neg,
   output logic bit_start
);

   localparam int PW   = (CLK_PER_BIT > 2) ? $clog2(CLK_PER_BIT) : 1;
   localparam int HALF = CLK_PER_BIT / 2;

   logic [PW-1:0] phase;
   logic          bit_end;
   logic          first_half;
   src_e          src;
   rails_t        direct;
   logic          ami_mark;
   rails_t        rails_q;
   logic [1:0]    rz_out;

   ami_bit_timer #(.CLK_PER_BIT(CLK_PER_BIT)) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .phase      (phase),
      .bit_end    (bit_end),
      .bit_begin  (bit_start),
      .first_half (first_half)
   );

   ami_src_select u_select (
      .dual_rail_mode (dual_rail_mode),
      .all_ones_req   (all_ones_req),
      .loopback_en    (loopback_en),
      .tx_pos         (tx_pos),
      .tx_neg         (tx_neg),
      .tx_data        (tx_data),
      .rx_pos         (rx_pos),
      .rx_neg         (rx_neg),
      .src            (src),
      .direct         (direct),
      .ami_mark       (ami_mark)
   );

   ami_polarity_enc u_enc (
      .clk      (clk),
      .rst_n    (rst_n),
      .bit_end  (bit_end),
      .direct   (direct),
      .ami_mark (ami_mark),
      .rails_q  (rails_q)
   );

   ami_rz_gate u_gate (
      .rails_q    (rails_q),
      .first_half (first_half),
      .rz_out     (rz_out)
   );

   assign line_pos = rz_out[1];
   assign line_neg = rz_out[0];

   p_half_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (phase >= PW'(HALF)) |-> (!line_pos && !line_neg));
   p_rails_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(line_pos && line_neg));
   p_loop_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_end && loopback_en) |=> (rails_q == clean_pair($past(rx_pos), $past(rx_neg))));
   p_ones_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_end && all_ones_req && !loopback_en) |=> (rails_q.pos || rails_q.neg));

endmodule

// File: tb/ami_line_tx_tb.sv
module ami_line_tx_tb;

   localparam int DIV  = 4;
   localparam int HALF = DIV / 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic dual_rail_mode = 0, all_ones_req = 0, loopback_en = 0;
   logic tx_pos = 0, tx_neg = 0, tx_data = 0, rx_pos = 0, rx_neg = 0;
   logic line_pos, line_neg, bit_start;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 0;
   bit exp_pol = 0;   // 0: next AMI mark positive

   always #5 clk = ~clk;

   ami_line_tx #(.CLK_PER_BIT(DIV)) u_dut (
      .clk(clk), .rst_n(rst_n), .dual_rail_mode(dual_rail_mode),
      .all_ones_req(all_ones_req), .loopback_en(loopback_en),
      .tx_pos(tx_pos), .tx_neg(tx_neg), .tx_data(tx_data),
      .rx_pos(rx_pos), .rx_neg(rx_neg),
      .line_pos(line_pos), .line_neg(line_neg), .bit_start(bit_start)
   );

   task automatic check(input string tag, input logic [2:0] act, input logic [2:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: {pos,neg,start} actual=%b expected=%b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic neutral();
      dual_rail_mode = 0; all_ones_req = 0; loopback_en = 0;
      tx_pos = 0; tx_neg = 0; tx_data = 0; rx_pos = 0; rx_neg = 0;
   endtask

   task automatic model(input logic [7:0] s, output logic ep, output logic en, output string tag);
      logic lb, ao, dm, tp, tn, td, rp, rn;
      {lb, ao, dm, tp, tn, td, rp, rn} = s;
      ep = 0; en = 0;
      if (lb) begin
         ep = rp & ~rn; en = rn & ~rp;
         tag = (rp & rn) ? "R7" : "R3";
      end else if (ao || (!dm && td)) begin
         ep = ~exp_pol; en = exp_pol; exp_pol = ~exp_pol;
         tag = ao ? ((dm | tp | tn | td) ? "R2" : "R1") : "R4";
      end else if (dm) begin
         ep = tp & ~tn; en = tn & ~tp;
         tag = (tp & tn) ? "R7" : "R6";
      end else begin
         tag = "R4";
      end
   endtask

   task automatic run_bit(input logic [7:0] s, input string force_tag);
      logic ep, en;
      string tag;
      while (!bit_start) @(negedge clk);
      {loopback_en, all_ones_req, dual_rail_mode, tx_pos, tx_neg, tx_data, rx_pos, rx_neg} = s;
      model(s, ep, en, tag);
      if (force_tag != "") tag = force_tag;
      // stimulus bit: shows the previous neutral bit, which had mid-bit toggles (R9)
      for (int k = 0; k < DIV; k++) begin
         check("R9", {line_pos, line_neg, bit_start}, {1'b0, 1'b0, (k == 0)});
         @(negedge clk);
      end
      neutral();
      for (int k = 0; k < DIV; k++) begin
         if (k < HALF) check(tag, {line_pos, line_neg, bit_start}, {ep, en, (k == 0)});
         else          check("R8", {line_pos, line_neg, bit_start}, {2'b00, 1'b0});
         if (k == 1) begin all_ones_req = 1; tx_data = 1; loopback_en = 1; rx_pos = 1; end
         if (k == 2) neutral();
         @(negedge clk);
      end
   endtask

   task automatic do_reset();
      rst_n = 0; neutral();
      repeat (3) @(negedge clk);
      check("R8", {line_pos, line_neg, 1'b0}, 3'b000);
      rst_n = 1;
      exp_pol = 0;
      @(negedge clk);
   endtask

   initial begin
      do_reset();
      // exhaustive sweep over {loopback, ones, mode, tx_pos, tx_neg, tx_data, rx_pos, rx_neg}
      for (int c = 0; c < 256; c++) run_bit(8'(c), "");
      // reset returns polarity to positive: first AMI mark after reset on line_pos (R5)
      do_reset();
      run_bit(8'b0000_0100, "R5");
      run_bit(8'b0000_0100, "R5");
      run_bit(8'b0010_1000, "R6");   // dual-rail mark, polarity kept
      run_bit(8'b0000_0100, "R5");
      run_bit(8'b1100_0001, "R3");   // loopback outranks alarm, no toggle
      run_bit(8'b0100_0000, "R1");
      run_bit(8'b0100_0000, "R1");
      run_bit(8'b0000_0000, "R4");
      done = 1;
   end

   initial begin
      int cyc = 0;
      while (!done && cyc < 200000) begin @(posedge clk); cyc++; end
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual=timeout expected=completion");
      end
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule